// File: doc/BRIEF.md
# DAC Sample Buffer Controller

This block holds a small table of 12-bit converter codes and chooses which one drives the converter input. Software loads each table slot over a byte-wide register bus in two writes: a low byte, then a high nibble. It also sets an upper slot limit, a watermark distance and two enables, and reads back slots, configuration, the read pointer and status.

With buffering off, slot 0 alone sets the output code, which passes through unchanged because the converter output is (1 + code)/4096 of its reference. With buffering on, each trigger pulse moves a read pointer one slot forward, and the slot under the pointer sets the output code. Past the upper limit the pointer wraps to slot 0.

Three sticky status flags record pointer events. A flag sets only in the cycle the pointer moves into its condition. Software clears a flag by writing 0 to its bit. When DMA mode is on, a completion pulse clears all flags. The output code is a level and not a stream, and every pin is plain control with no handshake.

Top module: `dacbuf_ctrl`

## Requirements
- R1: Slot n is written as a low byte at address 2n (data bits 7:0) and a high register at 2n+1 (bits 3:0 are data bits 11:8). The high register reads bits 7:4 as zero, and writes to those bits are ignored.
- R2: While buffering is off (control 0x21 bit 0 = 0), dac_code equals slot 0, and trigger pulses leave the pointer (read at 0x23) unchanged.
- R3: While buffering is on, dac_code equals the slot the pointer selects, and a trigger below the limit (0x22 bits 3:0) advances the pointer by one.
- R4: A trigger with the pointer at or above the limit wraps it to 0 and sets the top flag (status 0x20 bit 1).
- R5: A trigger that moves the pointer onto the limit sets the bottom flag (status bit 0).
- R6: A trigger that moves the pointer onto limit minus (1 + 0x22 bits 5:4) sets the watermark flag (status bit 2). Status bits 7:3 read as zero.
- R7: After reset, status reads 0x02, and the pointer, control, configuration and dac_code are all zero.
- R8: Writing a 0 to a status bit clears that bit. Writing a 1 leaves the bit unchanged.
- R9: Flags are sticky. A cleared flag stays clear while its condition persists with no new pointer move.
- R10: With DMA mode on (control bit 1), a dma_done pulse clears all flags. With DMA mode off, dma_done has no effect.
- R11: A flag-set event in the same cycle as a software or DMA clear wins, and the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 6 | Register address |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| trig | input | 1 | Trigger pulse that steps the pointer |
| dma_done | input | 1 | DMA completion pulse |
| dac_code | output | 12 | Code driven to the converter |

## Verification
The assertions assume that trig and dma_done are single-cycle pulses sampled at the clock, and that the bus makes at most one write per cycle. They also assume the flags change only through a trigger, a status write or a completion pulse. The bench drives every input from tasks, one clock after an edge, and holds each pulse high for exactly one cycle. It returns the strobes to zero before any read-back. The collision cases for R11 are made deliberately, by putting a status write or a completion pulse in the same cycle as a trigger.

// File: rtl/dacbuf_pkg.sv
package dacbuf_pkg;
  // register offsets above the slot window (window spans 2*ENTRIES bytes)
  localparam int STAT_OFS = 0;
  localparam int CTRL_OFS = 1;
  localparam int CFG_OFS  = 2;
  localparam int PTR_OFS  = 3;

  // status bit positions
  localparam int FLG_BOT = 0;
  localparam int FLG_TOP = 1;
  localparam int FLG_WM  = 2;
  localparam int FLG_W   = 3;

  // control bit positions
  localparam int CTL_BUF = 0;
  localparam int CTL_DMA = 1;

  // watermark distance select field in the configuration byte
  localparam int WM_LSB = 4;
  localparam int WM_W   = 2;

  typedef struct packed {
    logic wm;
    logic top;
    logic bot;
  } flag_ev_t;
endpackage

// File: rtl/dacbuf_slots.sv
module dacbuf_slots #(
  parameter int ENTRIES = 16,
  parameter int DATA_W  = 12,
  localparam int PTR_W  = $clog2(ENTRIES),
  localparam int HI_W   = DATA_W - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic              wr_hi,
  input  logic [7:0]        wr_data,
  input  logic [PTR_W-1:0]  bus_idx,
  input  logic              bus_hi,
  output logic [7:0]        bus_data,
  input  logic [PTR_W-1:0]  out_idx,
  output logic [DATA_W-1:0] out_code
);
  logic [DATA_W-1:0] slot_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (wr_en && wr_idx == PTR_W'(g)) begin
        if (wr_hi) slot_q[g][DATA_W-1:8] <= wr_data[HI_W-1:0];
        else       slot_q[g][7:0]        <= wr_data;
      end
    end
  end

  always_comb begin
    bus_data = '0;
    if (bus_hi) bus_data[HI_W-1:0] = slot_q[bus_idx][DATA_W-1:8];
    else        bus_data           = slot_q[bus_idx][7:0];
  end

  assign out_code = slot_q[out_idx];
endmodule

// File: rtl/dacbuf_pointer.sv
module dacbuf_pointer
  import dacbuf_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int PTR_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [PTR_W-1:0] limit,
  input  logic [WM_W-1:0]  wm_sel,
  output logic [PTR_W-1:0] ptr,
  output flag_ev_t         ev
);
  logic [PTR_W:0]   wm_dist;
  logic [PTR_W:0]   wm_pos_w;
  logic             wm_ok;
  logic             at_end;
  logic [PTR_W-1:0] nxt;

  assign wm_dist  = (PTR_W+1)'(wm_sel) + (PTR_W+1)'(1);
  assign wm_ok    = {1'b0, limit} >= wm_dist;
  assign wm_pos_w = {1'b0, limit} - wm_dist;
  assign at_end   = ptr >= limit;
  assign nxt      = at_end ? '0 : ptr + PTR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (step) ptr <= nxt;
  end

  always_comb begin
    ev     = '0;
    ev.top = step && at_end;
    ev.bot = step && !at_end && nxt == limit;
    ev.wm  = step && !at_end && wm_ok && nxt == wm_pos_w[PTR_W-1:0];
  end
endmodule

// File: rtl/dacbuf_flags.sv
module dacbuf_flags
  import dacbuf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  flag_ev_t         ev,
  input  logic             sw_wr,
  input  logic [FLG_W-1:0] sw_data,
  input  logic             dma_clr,
  output logic [FLG_W-1:0] flags
);
  logic [FLG_W-1:0] set_v;
  logic [FLG_W-1:0] nxt;

  always_comb begin
    set_v          = '0;
    set_v[FLG_BOT] = ev.bot;
    set_v[FLG_TOP] = ev.top;
    set_v[FLG_WM]  = ev.wm;
    nxt = flags;
    if (sw_wr)   nxt = nxt & sw_data;
    if (dma_clr) nxt = '0;
    nxt = nxt | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags          <= '0;
      flags[FLG_TOP] <= 1'b1;
    end else begin
      flags <= nxt;
    end
  end
endmodule

// File: rtl/dacbuf_ctrl.sv
module dacbuf_ctrl
  import dacbuf_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int DATA_W  = 12,
  parameter int ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              trig,
  input  logic              dma_done,
  output logic [DATA_W-1:0] dac_code
);
  localparam int PTR_W = $clog2(ENTRIES);
  localparam int WIN   = 2 * ENTRIES;
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(WIN + STAT_OFS);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(WIN + CTRL_OFS);
  localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(WIN + CFG_OFS);
  localparam logic [ADDR_W-1:0] PTR_A  = ADDR_W'(WIN + PTR_OFS);

  logic             buf_en_q, dma_en_q;
  logic [PTR_W-1:0] lim_q;
  logic [WM_W-1:0]  wm_q;
  logic [PTR_W-1:0] ptr_q;
  logic [FLG_W-1:0] flags_q;
  flag_ev_t         ev;
  logic             in_win;
  logic [PTR_W-1:0] win_idx;
  logic [7:0]       slot_rd;
  logic [DATA_W-1:0] slot_out;

  assign in_win  = reg_addr < ADDR_W'(WIN);
  assign win_idx = reg_addr[PTR_W:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_en_q <= 1'b0;
      dma_en_q <= 1'b0;
      lim_q    <= '0;
      wm_q     <= '0;
    end else if (reg_wr) begin
      if (reg_addr == CTRL_A) begin
        buf_en_q <= reg_wdata[CTL_BUF];
        dma_en_q <= reg_wdata[CTL_DMA];
      end
      if (reg_addr == CFG_A) begin
        lim_q <= reg_wdata[PTR_W-1:0];
        wm_q  <= reg_wdata[WM_LSB +: WM_W];
      end
    end
  end

  dacbuf_slots #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) slots_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr && in_win),
    .wr_idx   (win_idx),
    .wr_hi    (reg_addr[0]),
    .wr_data  (reg_wdata),
    .bus_idx  (win_idx),
    .bus_hi   (reg_addr[0]),
    .bus_data (slot_rd),
    .out_idx  (buf_en_q ? ptr_q : '0),
    .out_code (slot_out)
  );

  dacbuf_pointer #(.ENTRIES(ENTRIES)) ptr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (trig && buf_en_q),
    .limit  (lim_q),
    .wm_sel (wm_q),
    .ptr    (ptr_q),
    .ev     (ev)
  );

  dacbuf_flags flags_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev),
    .sw_wr   (reg_wr && reg_addr == STAT_A),
    .sw_data (reg_wdata[FLG_W-1:0]),
    .dma_clr (dma_done && dma_en_q),
    .flags   (flags_q)
  );

  assign dac_code = slot_out;

  always_comb begin
    reg_rdata = '0;
    if (in_win) begin
      reg_rdata = slot_rd;
    end else begin
      unique case (reg_addr)
        STAT_A: reg_rdata[FLG_W-1:0] = flags_q;
        CTRL_A: begin
          reg_rdata[CTL_BUF] = buf_en_q;
          reg_rdata[CTL_DMA] = dma_en_q;
        end
        CFG_A: begin
          reg_rdata[PTR_W-1:0]       = lim_q;
          reg_rdata[WM_LSB +: WM_W]  = wm_q;
        end
        PTR_A:   reg_rdata[PTR_W-1:0] = ptr_q;
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

module dacbuf_ctrl_chk #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 6,
  localparam int PTR_W  = $clog2(ENTRIES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [7:0]        reg_rdata,
  input logic              trig,
  input logic              dma_done,
  input logic              buf_en,
  input logic              dma_en,
  input logic [PTR_W-1:0]  ptr,
  input logic [PTR_W-1:0]  limit,
  input logic [2:0]        flags
);
  // R1
  hi_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr < ADDR_W'(2*ENTRIES) && reg_addr[0]) |-> reg_rdata[7:4] == 4'h0);

  // R2
  idle_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_en && trig) |=> ptr == $past(ptr));

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && trig && ptr < limit) |=> ptr == $past(ptr) + PTR_W'(1));

  // R4
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && trig && ptr >= limit) |=> (ptr == '0 && flags[1]));

  // R9
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && !reg_wr && !dma_done) |=> $stable(flags));

  // R10
  dma_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && dma_done && !trig) |=> flags == 3'b000);
endmodule

bind dacbuf_ctrl dacbuf_ctrl_chk #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rdata (reg_rdata),
  .trig      (trig),
  .dma_done  (dma_done),
  .buf_en    (buf_en_q),
  .dma_en    (dma_en_q),
  .ptr       (ptr_q),
  .limit     (lim_q),
  .flags     (flags_q)
);

// File: tb/dacbuf_ctrl_tb.sv
`timescale 1ns/1ps
module dacbuf_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       trig = 1'b0;
  logic       dma_done = 1'b0;
  logic [11:0] dac_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit          is_code;
    logic [11:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  dacbuf_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig(trig),
    .dma_done(dma_done), .dac_code(dac_code)
  );

  // monitor: pops one expected item per cycle and compares mid-cycle
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [11:0] act;
      it  = sb_q.pop_front();
      act = it.is_code ? dac_code : {4'h0, reg_rdata};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
      end
    end
  end

  function automatic logic [11:0] pat(int i);
    return 12'(i * 273 + 5);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic pulse_trig();
    trig = 1'b1; tick(); trig = 1'b0;
  endtask

  task automatic exp_reg(input logic [5:0] a, input logic [7:0] e, input string req);
    reg_addr = a;
    sb_q.push_back('{1'b0, {4'h0, e}, req});
    tick();
  endtask

  task automatic exp_code(input logic [11:0] e, input string req);
    sb_q.push_back('{1'b1, e, req});
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R7 reset state
    exp_reg(6'h20, 8'h02, "R7 status");
    exp_reg(6'h23, 8'h00, "R7 pointer");
    exp_reg(6'h21, 8'h00, "R7 control");
    exp_reg(6'h22, 8'h00, "R7 config");
    exp_code(12'h000, "R7 code");

    // R1 load slots, garbage in high nibble of high byte
    for (int i = 0; i < 16; i++) begin
      logic [11:0] v;
      v = pat(i);
      wr(6'(2*i), v[7:0]);
      wr(6'(2*i+1), {4'hA, v[11:8]});
    end
    for (int i = 0; i < 16; i += 5) begin
      logic [11:0] v;
      v = pat(i);
      exp_reg(6'(2*i), v[7:0], "R1 low");
      exp_reg(6'(2*i+1), {4'h0, v[11:8]}, "R1 high");
    end

    // R2 disabled: slot 0 drives, trigger ignored
    exp_code(pat(0), "R2 code");
    pulse_trig();
    exp_reg(6'h23, 8'h00, "R2 pointer");
    exp_code(pat(0), "R2 code after trig");

    // R8 write zero clears
    wr(6'h20, 8'h00);
    exp_reg(6'h20, 8'h00, "R8 clear");

    // limit 5, watermark distance 2 -> watermark at slot 3
    wr(6'h22, 8'h15);
    wr(6'h21, 8'h01);
    exp_code(pat(0), "R3 code at 0");
    pulse_trig();
    exp_reg(6'h23, 8'h01, "R3 pointer");
    exp_code(pat(1), "R3 code at 1");
    pulse_trig();
    pulse_trig();
    exp_reg(6'h20, 8'h04, "R6 watermark");
    pulse_trig();
    exp_reg(6'h20, 8'h04, "R6 only watermark");
    pulse_trig();
    exp_reg(6'h20, 8'h05, "R5 bottom");
    exp_code(pat(5), "R3 code at 5");
    wr(6'h20, 8'hFE);
    exp_reg(6'h20, 8'h04, "R8 write one keeps");
    tick(); tick();
    exp_reg(6'h20, 8'h04, "R9 sticky clear");
    pulse_trig();
    exp_reg(6'h20, 8'h06, "R4 top");
    exp_reg(6'h23, 8'h00, "R4 wrap");
    exp_code(pat(0), "R4 code");

    // R10 DMA clear
    dma_done = 1'b1; tick(); dma_done = 1'b0;
    exp_reg(6'h20, 8'h06, "R10 dma off");
    wr(6'h21, 8'h03);
    dma_done = 1'b1; tick(); dma_done = 1'b0;
    exp_reg(6'h20, 8'h00, "R10 dma on");

    // R11 set beats clear
    repeat (4) pulse_trig();
    wr(6'h20, 8'h00);
    exp_reg(6'h23, 8'h04, "R11 setup pointer");
    reg_addr = 6'h20; reg_wdata = 8'h00; reg_wr = 1'b1; trig = 1'b1;
    tick();
    reg_wr = 1'b0; trig = 1'b0;
    exp_reg(6'h20, 8'h01, "R11 set over write");
    trig = 1'b1; dma_done = 1'b1;
    tick();
    trig = 1'b0; dma_done = 1'b0;
    exp_reg(6'h20, 8'h02, "R11 set over dma");

    tick();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule